// File: doc/BRIEF.md
# Memory Self-Refresh Entry Controller

This block decides when a DRAM controller may drop into self-refresh and when it must be pulled back out. It sits beside a bus unit that carries isochronous display fetches. Each isochronous request carries the latency it can tolerate. The block holds memory out of self-refresh whenever a pending request could not survive the wake-up time. It also gates entry on a buffer-full interlock, and it only enters after memory has been idle for a programmed number of 250 ns ticks.

Software programs one 32-bit configuration word. The word holds four fields, all in 250 ns units:

- the exit latency,
- the scheduler latency used to flag requests as urgent,
- the idle entry delay,
- the entry threshold on required latency.

It also holds one bit that turns on the buffer-full interlock. The timebase is a single-cycle strobe input, so the block works the same at any clock frequency. After self-refresh ends, the block raises an exit-wait status for the programmed exit latency. Only once that time has passed does it report memory as ready.

Top module: `srf_entry_ctrl`

## Requirements
- R1: After reset, `sr_req` and `exit_wait` are 0, `mem_ready` is 1, and `cfg_rdata` reads 0x0400480C. That value means exit latency 12, scheduler latency 8, entry delay 4, interlock off and threshold 16.
- R2: Configuration bit 7 and bits 21:19 always read as 0. Ones written to them are dropped, so writing 0xFFFFFFFF reads back 0xFFC7FF7F.
- R3: The entry delay is held in bits 17:12. With no inhibit in force and `mem_idle` high, `sr_req` rises on the clock edge that samples the entry-delay-th `tick_250ns` strobe counted while idle.
- R4: An entry delay of 0 or 1 behaves as 2. One tick does not enter self-refresh; the second tick does.
- R5: A `req_valid` pulse, or `mem_idle` going low, restarts the idle tick count from zero.
- R6: The scheduler latency is held in bits 11:8. `req_urgent` is 1 exactly when `req_valid` is 1 and `req_lat` is at or below this value.
- R7: The entry threshold is held in bits 31:22. While `pend_valid` is 1 and `pend_min_lat` is strictly below the threshold, `sr_req` stays 0, and it drops in the same cycle if already high. When `pend_min_lat` equals the threshold, entry is allowed.
- R8: When bit 18 is 1, `buf_full` and `hp_blocked` both high block entry. When bit 18 is 0, that pair has no effect.
- R9: A request arriving while in self-refresh drops `sr_req` in the same cycle, without waiting for a clock edge.
- R10: After self-refresh ends, `exit_wait` is 1 and `mem_ready` is 0 until the exit-latency-th tick, where the exit latency is held in bits 6:0. After that tick, `mem_ready` returns to 1.
- R11: Without `tick_250ns` strobes, no amount of idle clock cycles leads to self-refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration word as held, reserved bits zero |
| tick_250ns | input | 1 | Single-cycle 250 ns timebase strobe |
| mem_idle | input | 1 | No memory traffic in flight |
| req_valid | input | 1 | New isochronous request this cycle |
| req_lat | input | LAT_W | Required latency of the new request, 250 ns units |
| pend_valid | input | 1 | At least one isochronous request pending |
| pend_min_lat | input | LAT_W | Smallest required latency among pending requests |
| buf_full | input | 1 | Request buffer full |
| hp_blocked | input | 1 | High-priority request blocked at admission |
| sr_req | output | 1 | Self-refresh request to the DRAM unit |
| req_urgent | output | 1 | Current request is high priority |
| exit_wait | output | 1 | Self-refresh exit in progress |
| mem_ready | output | 1 | Memory available for traffic |

## Verification
The bench first runs long idle stretches without strobes, then runs counted strobe sequences. This separates a controller that counts ticks from one that counts clocks. The tests use entry delays of 4, 1 and 0, so off-by-one counting and a missing clamp show up as a change in the edge where `sr_req` rises. Pending latencies of 15 and 16 are tried against a threshold of 16, which separates a strict compare from an inclusive one. The same buffer-full and blocked pair is driven with the interlock bit on and off. Finally, a wake-up is triggered with the exit latency set to 12 and to 3, which ties the length of `exit_wait` to the programmed field.

// File: rtl/srf_pkg.sv
// Shared definitions for the self-refresh entry controller.
// Assumes the configuration word is 32 bits; the field positions below are the
// software-visible layout and must not move.
package srf_pkg;

    localparam int CFG_W     = 32;
    localparam int EXIT_LSB  = 0;
    localparam int EXIT_W    = 7;
    localparam int SCHED_LSB = 8;
    localparam int SCHED_W   = 4;
    localparam int DLY_LSB   = 12;
    localparam int DLY_W     = 6;
    localparam int SYNC_BIT  = 18;
    localparam int THR_LSB   = 22;
    localparam int THR_W     = 10;
    localparam int CNT_W     = (EXIT_W > DLY_W) ? EXIT_W : DLY_W;

    // Reserved positions: bit 7 and bits 21:19
    localparam logic [CFG_W-1:0] RSV_MASK = 32'h0038_0080;

    typedef enum logic [1:0] {
        ST_ACTIVE   = 2'd0,
        ST_COUNTING = 2'd1,
        ST_SELF_REF = 2'd2,
        ST_EXITING  = 2'd3
    } srf_state_e;

    typedef struct packed {
        logic [THR_W-1:0]   thr;
        logic               sync_en;
        logic [DLY_W-1:0]   dly;
        logic [SCHED_W-1:0] sched;
        logic [EXIT_W-1:0]  exit_lat;
    } srf_cfg_t;

endpackage

// File: rtl/srf_cfg_regs.sv
// Configuration register for the self-refresh controller.
// Holds the 32-bit word with reserved bits forced to zero, splits it into
// fields and clamps the entry delay to MIN_DLY. Assumes writes are single-cycle.
module srf_cfg_regs
    import srf_pkg::*;
#(
    parameter logic [CFG_W-1:0] RST_WORD = 32'h0400_480C,
    parameter int               MIN_DLY  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output logic [CFG_W-1:0] word,
    output srf_cfg_t         fields
);

    localparam logic [DLY_W-1:0] MIN_DLY_V = DLY_W'(MIN_DLY);

    logic [CFG_W-1:0] word_q;
    logic [DLY_W-1:0] dly_raw;

    // Hold the configuration word; reserved bits never store a one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= RST_WORD & ~RSV_MASK;
        end else if (wr_en) begin
            word_q <= wr_data & ~RSV_MASK;
        end
    end

    // Split fields and apply the minimum entry delay
    always_comb begin
        dly_raw          = word_q[DLY_LSB +: DLY_W];
        fields.exit_lat  = word_q[EXIT_LSB +: EXIT_W];
        fields.sched     = word_q[SCHED_LSB +: SCHED_W];
        fields.sync_en   = word_q[SYNC_BIT];
        fields.thr       = word_q[THR_LSB +: THR_W];
        fields.dly       = (dly_raw < MIN_DLY_V) ? MIN_DLY_V : dly_raw;
    end

    assign word = word_q;

endmodule

// File: rtl/srf_gate.sv
// Latency gate: flags urgent requests and forms the inhibit that keeps DRAM
// out of self-refresh. Purely combinational; assumes LAT_W >= 1.
module srf_gate
    import srf_pkg::*;
#(
    parameter int LAT_W = 10
) (
    input  srf_cfg_t         cfg,
    input  logic             req_valid,
    input  logic [LAT_W-1:0] req_lat,
    input  logic             pend_valid,
    input  logic [LAT_W-1:0] pend_min_lat,
    input  logic             buf_full,
    input  logic             hp_blocked,
    input  logic             mem_idle,
    output logic             req_urgent,
    output logic             inhibit
);

    localparam int CW = (LAT_W > THR_W) ? LAT_W : THR_W;

    logic [CW-1:0] sched_x;
    logic [CW-1:0] thr_x;
    logic [CW-1:0] req_x;
    logic [CW-1:0] pend_x;
    logic          thr_hit;
    logic          lock_hit;

    // Widen all latency operands to a common width
    always_comb begin
        sched_x = CW'(cfg.sched);
        thr_x   = CW'(cfg.thr);
        req_x   = CW'(req_lat);
        pend_x  = CW'(pend_min_lat);
    end

    // Compare latencies against the programmed limits
    always_comb begin
        req_urgent = req_valid && (req_x <= sched_x);
        thr_hit    = pend_valid && (pend_x < thr_x);
        lock_hit   = cfg.sync_en && buf_full && hp_blocked;
        inhibit    = req_valid || !mem_idle || thr_hit || lock_hit;
    end

endmodule

// File: rtl/srf_tick_cnt.sv
// Saturating counter of timebase strobes with synchronous clear.
// Assumes the strobe is one clock wide; clear wins over counting.
module srf_tick_cnt #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         tick,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] MAXV = '1;

    // Count strobes, hold at the maximum, restart on clear
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count <= '0;
        end else if (tick && count != MAXV) begin
            count <= count + W'(1);
        end
    end

endmodule

// File: rtl/srf_fsm.sv
// Self-refresh sequencer: ACTIVE -> COUNTING -> SELF_REF -> EXITING -> ACTIVE.
// Assumes dly is already clamped to at least 1 and counters are cleared by the
// clear outputs of this module.
module srf_fsm
    import srf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              inhibit,
    input  logic [DLY_W-1:0]  dly,
    input  logic [EXIT_W-1:0] exit_lat,
    input  logic [CNT_W-1:0]  idle_cnt,
    input  logic [CNT_W-1:0]  exit_cnt,
    output logic              idle_clr,
    output logic              exit_clr,
    output logic              sr_req,
    output logic              exit_wait,
    output logic              mem_ready
);

    srf_state_e      state_q, state_d;
    logic [CNT_W:0]  idle_next;
    logic [CNT_W:0]  exit_next;
    logic            entry_done;
    logic            exit_done;

    // Evaluate whether the current tick completes a wait
    always_comb begin
        idle_next  = {1'b0, idle_cnt} + (CNT_W+1)'(1);
        exit_next  = {1'b0, exit_cnt} + (CNT_W+1)'(1);
        entry_done = tick && (idle_next >= (CNT_W+1)'(dly));
        exit_done  = (exit_lat == '0) ||
                     (tick && (exit_next >= (CNT_W+1)'(exit_lat)));
    end

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACTIVE:   if (!inhibit)  state_d = ST_COUNTING;
            ST_COUNTING: if (inhibit)   state_d = ST_ACTIVE;
                         else if (entry_done) state_d = ST_SELF_REF;
            ST_SELF_REF: if (inhibit)   state_d = ST_EXITING;
            ST_EXITING:  if (exit_done) state_d = ST_ACTIVE;
            default:                    state_d = ST_ACTIVE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ACTIVE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs and counter control
    always_comb begin
        idle_clr  = (state_q != ST_COUNTING) || inhibit;
        exit_clr  = (state_q != ST_EXITING);
        sr_req    = (state_q == ST_SELF_REF) && !inhibit;
        exit_wait = (state_q == ST_EXITING);
        mem_ready = (state_q == ST_ACTIVE) || (state_q == ST_COUNTING);
    end

endmodule

// File: rtl/srf_entry_ctrl.sv
// Top of the self-refresh entry controller. Ties the configuration register,
// latency gate, two tick counters and the sequencer together.
// Assumes tick_250ns is a one-cycle strobe and inputs are synchronous to clk.
module srf_entry_ctrl
    import srf_pkg::*;
#(
    parameter int               LAT_W    = 10,
    parameter logic [31:0]      RST_WORD = 32'h0400_480C,
    parameter int               MIN_DLY  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata,
    input  logic             tick_250ns,
    input  logic             mem_idle,
    input  logic             req_valid,
    input  logic [LAT_W-1:0] req_lat,
    input  logic             pend_valid,
    input  logic [LAT_W-1:0] pend_min_lat,
    input  logic             buf_full,
    input  logic             hp_blocked,
    output logic             sr_req,
    output logic             req_urgent,
    output logic             exit_wait,
    output logic             mem_ready
);

    srf_cfg_t         cfg;
    logic             inhibit;
    logic             idle_clr;
    logic             exit_clr;
    logic [CNT_W-1:0] idle_cnt;
    logic [CNT_W-1:0] exit_cnt;

    srf_cfg_regs #(
        .RST_WORD (RST_WORD),
        .MIN_DLY  (MIN_DLY)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .wr_data (cfg_wdata),
        .word    (cfg_rdata),
        .fields  (cfg)
    );

    srf_gate #(
        .LAT_W (LAT_W)
    ) u_gate (
        .cfg          (cfg),
        .req_valid    (req_valid),
        .req_lat      (req_lat),
        .pend_valid   (pend_valid),
        .pend_min_lat (pend_min_lat),
        .buf_full     (buf_full),
        .hp_blocked   (hp_blocked),
        .mem_idle     (mem_idle),
        .req_urgent   (req_urgent),
        .inhibit      (inhibit)
    );

    srf_tick_cnt #(.W(CNT_W)) u_idle_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (idle_clr),
        .tick  (tick_250ns),
        .count (idle_cnt)
    );

    srf_tick_cnt #(.W(CNT_W)) u_exit_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (exit_clr),
        .tick  (tick_250ns),
        .count (exit_cnt)
    );

    srf_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_250ns),
        .inhibit   (inhibit),
        .dly       (cfg.dly),
        .exit_lat  (cfg.exit_lat),
        .idle_cnt  (idle_cnt),
        .exit_cnt  (exit_cnt),
        .idle_clr  (idle_clr),
        .exit_clr  (exit_clr),
        .sr_req    (sr_req),
        .exit_wait (exit_wait),
        .mem_ready (mem_ready)
    );

endmodule

// File: rtl/srf_entry_ctrl_chk.sv
// Property checker for srf_entry_ctrl, attached through bind below.
module srf_entry_ctrl_chk #(
    parameter int LAT_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic [31:0]      cfg_rdata,
    input logic             req_valid,
    input logic [LAT_W-1:0] req_lat,
    input logic             pend_valid,
    input logic [LAT_W-1:0] pend_min_lat,
    input logic             buf_full,
    input logic             hp_blocked,
    input logic             sr_req,
    input logic             req_urgent,
    input logic             exit_wait,
    input logic             mem_ready
);

    localparam int CW = (LAT_W > 10) ? LAT_W : 10;

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[7] == 1'b0) && (cfg_rdata[21:19] == 3'b000)); // R2

    AST_URGENT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_urgent |-> (req_valid && (CW'(req_lat) <= CW'(cfg_rdata[11:8])))); // R6

    AST_THR_KEEPS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_valid && (CW'(pend_min_lat) < CW'(cfg_rdata[31:22]))) |-> !sr_req); // R7

    AST_LOCK_KEEPS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[18] && buf_full && hp_blocked) |-> !sr_req); // R8

    AST_REQ_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !sr_req); // R9

    AST_EXIT_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        exit_wait |-> (!mem_ready && !sr_req)); // R10

    AST_EXIT_ENDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(exit_wait) |-> mem_ready); // R10

endmodule

bind srf_entry_ctrl srf_entry_ctrl_chk #(.LAT_W(LAT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_rdata    (cfg_rdata),
    .req_valid    (req_valid),
    .req_lat      (req_lat),
    .pend_valid   (pend_valid),
    .pend_min_lat (pend_min_lat),
    .buf_full     (buf_full),
    .hp_blocked   (hp_blocked),
    .sr_req       (sr_req),
    .req_urgent   (req_urgent),
    .exit_wait    (exit_wait),
    .mem_ready    (mem_ready)
);

// File: tb/srf_entry_ctrl_tb.sv
// Scoreboard bench: the driver queues expectations, the monitor compares them.
module srf_entry_ctrl_tb_top;

    localparam int LAT_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_wr = 1'b0;
    logic [31:0]      cfg_wdata = '0;
    logic [31:0]      cfg_rdata;
    logic             tick_250ns = 1'b0;
    logic             mem_idle = 1'b0;
    logic             req_valid = 1'b0;
    logic [LAT_W-1:0] req_lat = '0;
    logic             pend_valid = 1'b0;
    logic [LAT_W-1:0] pend_min_lat = '0;
    logic             buf_full = 1'b0;
    logic             hp_blocked = 1'b0;
    logic             sr_req;
    logic             req_urgent;
    logic             exit_wait;
    logic             mem_ready;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct {
        string       rq;
        int          sel;
        logic [31:0] exp;
    } item_t;

    item_t q[$];
    event  chk_ev;

    always #2.5 clk = ~clk;

    srf_entry_ctrl #(.LAT_W(LAT_W)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr       (cfg_wr),
        .cfg_wdata    (cfg_wdata),
        .cfg_rdata    (cfg_rdata),
        .tick_250ns   (tick_250ns),
        .mem_idle     (mem_idle),
        .req_valid    (req_valid),
        .req_lat      (req_lat),
        .pend_valid   (pend_valid),
        .pend_min_lat (pend_min_lat),
        .buf_full     (buf_full),
        .hp_blocked   (hp_blocked),
        .sr_req       (sr_req),
        .req_urgent   (req_urgent),
        .exit_wait    (exit_wait),
        .mem_ready    (mem_ready)
    );

    function automatic logic [31:0] observe(int sel);
        case (sel)
            0:       return {31'd0, sr_req};
            1:       return {31'd0, exit_wait};
            2:       return {31'd0, mem_ready};
            3:       return {31'd0, req_urgent};
            default: return cfg_rdata;
        endcase
    endfunction

    // Monitor: pop queued expectations and compare with live outputs
    initial begin
        forever begin
            @(chk_ev);
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                act = observe(it.sel);
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s sel=%0d actual=%h expected=%h", it.rq, it.sel, act, it.exp);
                end
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(string rq, int sel, logic [31:0] exp);
        item_t it;
        it.rq = rq; it.sel = sel; it.exp = exp;
        q.push_back(it);
        -> chk_ev;
        wait (q.size() == 0);
    endtask

    task automatic pulses(int n);
        for (int i = 0; i < n; i++) begin
            tick_250ns = 1'b1;
            step(1);
            tick_250ns = 1'b0;
            step(1);
        end
    endtask

    task automatic write_cfg(logic [31:0] v);
        cfg_wr = 1'b1;
        cfg_wdata = v;
        step(1);
        cfg_wr = 1'b0;
    endtask

    task automatic go_idle();
        mem_idle = 1'b1;
        step(2);
    endtask

    // Wake from self-refresh with a request, then time out the exit wait
    task automatic wake_and_exit(int e);
        req_valid = 1'b1;
        #1;
        expect_out("R9 sr_req drops on request", 0, 32'd0);
        step(1);
        req_valid = 1'b0;
        mem_idle = 1'b0;
        expect_out("R10 exit_wait raised", 1, 32'd1);
        expect_out("R10 not ready in exit", 2, 32'd0);
        if (e > 1) pulses(e - 1);
        expect_out("R10 exit_wait held before last tick", 1, 32'd1);
        pulses(1);
        expect_out("R10 exit_wait released", 1, 32'd0);
        expect_out("R10 ready after exit", 2, 32'd1);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog
    initial begin
        #(5 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    // Driver
    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        expect_out("R1 cfg reset", 4, 32'h0400_480C);
        expect_out("R1 sr_req reset", 0, 32'd0);
        expect_out("R1 exit_wait reset", 1, 32'd0);
        expect_out("R1 mem_ready reset", 2, 32'd1);

        // R11: idle clocks without strobes
        mem_idle = 1'b1;
        step(20);
        expect_out("R11 no entry without ticks", 0, 32'd0);
        // R3: entry on the 4th tick
        pulses(3);
        expect_out("R3 not yet after 3 ticks", 0, 32'd0);
        pulses(1);
        expect_out("R3 entered after 4 ticks", 0, 32'd1);
        wake_and_exit(12);

        // R5: a request restarts the count
        go_idle();
        pulses(3);
        req_valid = 1'b1;
        step(1);
        req_valid = 1'b0;
        step(2);
        pulses(3);
        expect_out("R5 count restarted", 0, 32'd0);
        pulses(1);
        expect_out("R5 entry after full restart", 0, 32'd1);
        wake_and_exit(12);

        // R6: urgency against scheduler latency 8
        req_valid = 1'b1; req_lat = 10'd8; #1;
        expect_out("R6 lat 8 urgent", 3, 32'd1);
        req_lat = 10'd9; #1;
        expect_out("R6 lat 9 not urgent", 3, 32'd0);
        req_valid = 1'b0; req_lat = 10'd3; #1;
        expect_out("R6 no request not urgent", 3, 32'd0);
        step(2);

        // R4: delay 0 and 1 clamp to 2
        write_cfg(32'h0400_080C);
        expect_out("R4 cfg delay 0", 4, 32'h0400_080C);
        go_idle();
        pulses(1);
        expect_out("R4 delay0 one tick", 0, 32'd0);
        pulses(1);
        expect_out("R4 delay0 two ticks", 0, 32'd1);
        wake_and_exit(12);
        write_cfg(32'h0400_180C);
        go_idle();
        pulses(1);
        expect_out("R4 delay1 one tick", 0, 32'd0);
        pulses(1);
        expect_out("R4 delay1 two ticks", 0, 32'd1);
        wake_and_exit(12);

        // R7: threshold 16
        write_cfg(32'h0400_480C);
        pend_valid = 1'b1; pend_min_lat = 10'd15;
        go_idle();
        pulses(6);
        expect_out("R7 lat 15 keeps out", 0, 32'd0);
        pend_min_lat = 10'd16;
        step(2);
        pulses(4);
        expect_out("R7 lat 16 allows entry", 0, 32'd1);
        pend_min_lat = 10'd15; #1;
        expect_out("R7 lat 15 drops sr_req", 0, 32'd0);
        pend_min_lat = 10'd16;
        wake_and_exit(12);
        pend_valid = 1'b0;

        // R8: interlock on, then off
        write_cfg(32'h0404_480C);
        buf_full = 1'b1; hp_blocked = 1'b1;
        go_idle();
        pulses(6);
        expect_out("R8 interlock blocks", 0, 32'd0);
        hp_blocked = 1'b0;
        step(2);
        pulses(4);
        expect_out("R8 entry once unblocked", 0, 32'd1);
        wake_and_exit(12);
        write_cfg(32'h0400_480C);
        hp_blocked = 1'b1;
        go_idle();
        pulses(4);
        expect_out("R8 pair ignored when bit off", 0, 32'd1);
        wake_and_exit(12);
        buf_full = 1'b0; hp_blocked = 1'b0;

        // R10: exit latency 3
        write_cfg(32'h0400_4803);
        go_idle();
        pulses(4);
        expect_out("R10 entered for short exit", 0, 32'd1);
        wake_and_exit(3);

        // R2: reserved bits read zero
        write_cfg(32'hFFFF_FFFF);
        expect_out("R2 reserved bits zero", 4, 32'hFFC7_FF7F);

        done = 1'b1;
        summary();
    end

endmodule